// File: doc/BRIEF.md
# Identifier CRC-8 Integrity Checker

This block checks the integrity of a 64-bit device identifier. The identifier has three fields. The low byte is a family code. The next 48 bits are a serial number. The top byte is a CRC over the 56 bits below it. The check runs a serial CRC-8 register with generator x^8 + x^5 + x^4 + 1. The register clears to zero and takes the identifier one bit per clock, bit 0 first. After the 56-bit prefix, the register holds the expected CRC byte. Shifting the stored CRC byte through as well leaves a zero residue when the identifier is intact.

The identifier can arrive in two ways. A parallel load strobe captures a whole word, which an internal serialiser then feeds to the CRC engine over 64 clocks. Alternatively, an upstream receiver can present the bits one at a time on a serial strobe. In both cases the block ends with a one-cycle completion pulse. It then reports separate verdicts for the family code and for the CRC, plus a combined verdict. It also exposes the CRC value computed over the prefix, so the block can generate the check byte for a new identifier.

Top module: `rom_id_crc_checker`

## Requirements
- R1: After reset, `busy`, `done`, `crc_calc_vld`, `crc_ok`, `fam_ok` and `id_ok` are 0 and `crc_calc` is 00h.
- R2: The CRC register starts at zero and takes bits in order from bit 0 upward with generator x^8+x^5+x^4+1. When the 56th bit is taken, `crc_calc` becomes the CRC of identifier bits 55..0 and `crc_calc_vld` goes to 1.
- R3: A `load` pulse captures `id_word`. `busy` is 1 on the following cycle. `done` is a single-cycle pulse, high in the 64th cycle after the load edge, and `busy` is 0 at that point.
- R4: At `done`, `crc_ok` is 1 exactly when the residue is zero after all 64 bits. This is the case when bits 63..56 equal the CRC of bits 55..0.
- R5: At `done`, `fam_ok` is 1 exactly when bits 7..0 equal the FAMILY parameter (default 2Dh).
- R6: `id_ok` is 1 exactly when both `crc_ok` and `fam_ok` are 1.
- R7: A `load` that arrives while a check is running restarts the check from a cleared register with the new word. `done` then comes 64 cycles after the latest load, and the verdicts describe the new word.
- R8: `ser_clr` clears the register and the results. Each later cycle with `ser_vld` high and `busy` low takes `ser_bit` as the next bit. `done` is high in the cycle after the 64th bit is taken, and gaps between bits are allowed.
- R9: Serial bits have no effect while `busy` is 1. Serial bits presented after the 64th bit also have no effect until the next clear.
- R10: All results hold their values until the next `load` or `ser_clr`. Either of these clears `done`, `crc_calc_vld`, `crc_ok` and `fam_ok` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture `id_word` and start a parallel check |
| id_word | input | 64 | Identifier for the parallel mode |
| ser_clr | input | 1 | Clear the register and results before serial entry |
| ser_vld | input | 1 | Serial bit strobe |
| ser_bit | input | 1 | Serial data bit, bit 0 first |
| busy | output | 1 | Serialiser is feeding the CRC engine |
| done | output | 1 | One-cycle pulse when 64 bits have been taken |
| crc_calc | output | 8 | CRC computed over the 56-bit prefix |
| crc_calc_vld | output | 1 | `crc_calc` holds a prefix CRC |
| crc_ok | output | 1 | Zero residue after 64 bits |
| fam_ok | output | 1 | Family code matches FAMILY |
| id_ok | output | 1 | Both verdicts pass |

## Verification
The bench builds the block with its default parameters: a 64-bit identifier, an 8-bit CRC and an 8-bit family field with FAMILY = 2Dh, the generator constant 31h, and the right-shifting bit-0-first variant. With these values the bench can test identifiers of the real layout, with the prefix CRC captured after exactly 56 bits and the residue examined after 64. Random identifiers are mixed with constructed valid ones. This exercises each verdict on its own: correct CRC with a wrong family, a matching family with a corrupted CRC byte, and the all-zero word whose CRC is zero. The bench also covers restarts in mid-check and serial streams with gaps.

// File: rtl/rid_pkg.sv
package rid_pkg;
   localparam int unsigned ID_W_DFLT  = 64;
   localparam int unsigned CRC_W_DFLT = 8;
   localparam int unsigned FAM_W_DFLT = 8;
   localparam logic [7:0]  FAMILY_DFLT = 8'h2D;
   // generator x^8+x^5+x^4+1 in normal (msb-first) notation
   localparam logic [7:0]  POLY_DFLT   = 8'h31;

   typedef struct packed {
      logic crc_ok;
      logic fam_ok;
   } rid_verdict_t;
endpackage

// File: rtl/rid_crc_step.sv
module rid_crc_step #(
   parameter int unsigned       CRC_W       = 8,
   parameter logic [CRC_W-1:0]  POLY        = 8'h31,
   parameter bit                SHIFT_RIGHT = 1'b1
) (
   input  logic [CRC_W-1:0] crc_i,
   input  logic             bit_i,
   output logic [CRC_W-1:0] crc_o
);
   logic [CRC_W-1:0] poly_r;

   generate
      for (genvar g = 0; g < CRC_W; g++) begin : g_refl
         assign poly_r[g] = POLY[CRC_W-1-g];
      end

      if (SHIFT_RIGHT) begin : g_rshift
         logic fb;
         always_comb begin
            fb    = crc_i[0] ^ bit_i;
            crc_o = (crc_i >> 1) ^ (fb ? poly_r : '0);
         end
      end else begin : g_lshift
         logic fb;
         always_comb begin
            fb    = crc_i[CRC_W-1] ^ bit_i;
            crc_o = (crc_i << 1) ^ (fb ? POLY : '0);
         end
      end
   endgenerate
endmodule

// File: rtl/rid_serializer.sv
module rid_serializer #(
   parameter int unsigned ID_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            abort,
   input  logic [ID_W-1:0] word,
   output logic            busy,
   output logic            bit_o
);
   localparam int unsigned CW = $clog2(ID_W + 1);
   localparam logic [CW-1:0] FULL = CW'(ID_W);
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [ID_W-1:0] sh_q;
   logic [CW-1:0]   left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         sh_q   <= word;
         left_q <= FULL;
      end else if (abort) begin
         left_q <= '0;
      end else if (left_q != '0) begin
         sh_q   <= sh_q >> 1;
         left_q <= left_q - ONE;
      end
   end

   assign busy  = (left_q != '0);
   assign bit_o = sh_q[0];
endmodule

// File: rtl/rid_track.sv
module rid_track
   import rid_pkg::*;
#(
   parameter int unsigned       ID_W        = 64,
   parameter int unsigned       CRC_W       = 8,
   parameter int unsigned       FAM_W       = 8,
   parameter logic [FAM_W-1:0]  FAMILY      = 8'h2D,
   parameter logic [CRC_W-1:0]  POLY        = 8'h31,
   parameter bit                SHIFT_RIGHT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift_en,
   input  logic             bit_i,
   output logic [CRC_W-1:0] crc_calc,
   output logic             crc_calc_vld,
   output logic             done,
   output rid_verdict_t     verdict
);
   localparam int unsigned   CW       = $clog2(ID_W + 1);
   localparam int unsigned   PRE_W    = ID_W - CRC_W;
   localparam logic [CW-1:0] N_FULL   = CW'(ID_W);
   localparam logic [CW-1:0] N_LAST   = CW'(ID_W - 1);
   localparam logic [CW-1:0] N_PRE    = CW'(PRE_W - 1);
   localparam logic [CW-1:0] N_FAM    = CW'(FAM_W);
   localparam logic [CW-1:0] ONE      = CW'(1);

   logic [CRC_W-1:0] crc_q, crc_nx;
   logic [CW-1:0]    nbits_q;
   logic [FAM_W-1:0] fam_q;
   logic             take;

   rid_crc_step #(
      .CRC_W       (CRC_W),
      .POLY        (POLY),
      .SHIFT_RIGHT (SHIFT_RIGHT)
   ) u_step (
      .crc_i (crc_q),
      .bit_i (bit_i),
      .crc_o (crc_nx)
   );

   assign take = shift_en && (nbits_q != N_FULL);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         crc_q        <= '0;
         nbits_q      <= '0;
         fam_q        <= '0;
         crc_calc     <= '0;
         crc_calc_vld <= 1'b0;
         done         <= 1'b0;
         verdict      <= '0;
      end else begin
         done <= 1'b0;
         if (take) begin
            crc_q   <= crc_nx;
            nbits_q <= nbits_q + ONE;
            if (nbits_q < N_FAM)
               fam_q <= {bit_i, fam_q[FAM_W-1:1]};
            if (nbits_q == N_PRE) begin
               crc_calc     <= crc_nx;
               crc_calc_vld <= 1'b1;
            end
            if (nbits_q == N_LAST) begin
               done           <= 1'b1;
               verdict.crc_ok <= (crc_nx == '0);
               verdict.fam_ok <= (fam_q == FAMILY);
            end
         end
      end
   end
endmodule

// File: rtl/rom_id_crc_checker.sv
module rom_id_crc_checker
   import rid_pkg::*;
#(
   parameter int unsigned       ID_W        = ID_W_DFLT,
   parameter int unsigned       CRC_W       = CRC_W_DFLT,
   parameter int unsigned       FAM_W       = FAM_W_DFLT,
   parameter logic [FAM_W-1:0]  FAMILY      = FAMILY_DFLT,
   parameter logic [CRC_W-1:0]  POLY        = POLY_DFLT,
   parameter bit                SHIFT_RIGHT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ID_W-1:0]  id_word,
   input  logic             ser_clr,
   input  logic             ser_vld,
   input  logic             ser_bit,
   output logic             busy,
   output logic             done,
   output logic [CRC_W-1:0] crc_calc,
   output logic             crc_calc_vld,
   output logic             crc_ok,
   output logic             fam_ok,
   output logic             id_ok
);
   generate
      if (ID_W <= CRC_W + FAM_W) begin : g_bad_layout
         $error("identifier too short for family and CRC fields");
      end
      if (CRC_W < 2) begin : g_bad_crc
         $error("CRC width must be at least 2");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("generator must include the x^0 term");
      end
   endgenerate

   logic         clr, par_busy, par_bit, shift_en, bit_sel;
   rid_verdict_t verdict;

   assign clr      = load | ser_clr;
   assign shift_en = par_busy | (ser_vld & ~clr);
   assign bit_sel  = par_busy ? par_bit : ser_bit;

   rid_serializer #(.ID_W(ID_W)) u_ser (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .abort (ser_clr),
      .word  (id_word),
      .busy  (par_busy),
      .bit_o (par_bit)
   );

   rid_track #(
      .ID_W        (ID_W),
      .CRC_W       (CRC_W),
      .FAM_W       (FAM_W),
      .FAMILY      (FAMILY),
      .POLY        (POLY),
      .SHIFT_RIGHT (SHIFT_RIGHT)
   ) u_trk (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr          (clr),
      .shift_en     (shift_en),
      .bit_i        (bit_sel),
      .crc_calc     (crc_calc),
      .crc_calc_vld (crc_calc_vld),
      .done         (done),
      .verdict      (verdict)
   );

   assign busy   = par_busy;
   assign crc_ok = verdict.crc_ok;
   assign fam_ok = verdict.fam_ok;
   assign id_ok  = verdict.crc_ok & verdict.fam_ok;
endmodule

// File: rtl/rid_checker.sv
module rid_checker #(
   parameter int unsigned CRC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load,
   input logic             ser_clr,
   input logic             ser_vld,
   input logic             busy,
   input logic             done,
   input logic [CRC_W-1:0] crc_calc,
   input logic             crc_calc_vld,
   input logic             crc_ok,
   input logic             fam_ok,
   input logic             id_ok
);
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy);

   assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_prefix_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> crc_calc_vld);

   assert_verdict_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_ok) |-> done);

   assert_pass_needs_prefix_R6: assert property (@(posedge clk) disable iff (!rst_n)
      id_ok |-> crc_calc_vld);

   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load || ser_clr) |=> (!done && !crc_calc_vld && !crc_ok && !fam_ok));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load && !ser_clr && !ser_vld) |=>
         ($stable(crc_calc) && $stable(crc_ok) && $stable(fam_ok)));
endmodule

bind rom_id_crc_checker rid_checker #(.CRC_W(CRC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .load         (load),
   .ser_clr      (ser_clr),
   .ser_vld      (ser_vld),
   .busy         (busy),
   .done         (done),
   .crc_calc     (crc_calc),
   .crc_calc_vld (crc_calc_vld),
   .crc_ok       (crc_ok),
   .fam_ok       (fam_ok),
   .id_ok        (id_ok)
);

// File: tb/sim_rom_id_crc_checker.sv
module sim_rom_id_crc_checker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [63:0] id_word = '0;
   logic        ser_clr = 1'b0;
   logic        ser_vld = 1'b0;
   logic        ser_bit = 1'b0;
   logic        busy, done, crc_calc_vld, crc_ok, fam_ok, id_ok;
   logic [7:0]  crc_calc;

   int n_chk = 0;
   int n_fail = 0;
   int unsigned seed_dummy;

   always #5 clk = ~clk;

   rom_id_crc_checker u0 (
      .clk(clk), .rst_n(rst_n), .load(load), .id_word(id_word),
      .ser_clr(ser_clr), .ser_vld(ser_vld), .ser_bit(ser_bit),
      .busy(busy), .done(done), .crc_calc(crc_calc),
      .crc_calc_vld(crc_calc_vld), .crc_ok(crc_ok), .fam_ok(fam_ok),
      .id_ok(id_ok)
   );

   function automatic logic [7:0] crc_of(input logic [55:0] d);
      logic [7:0] c = 8'h00;
      for (int i = 0; i < 56; i++) begin
         logic fb = c[0] ^ d[i];
         c = c >> 1;
         if (fb) c = c ^ 8'h8C;
      end
      return c;
   endfunction

   function automatic logic [63:0] make_good(input logic [47:0] sn, input logic [7:0] fam);
      logic [55:0] p = {sn, fam};
      return {crc_of(p), p};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_results(input logic [63:0] id, input string tag);
      logic [7:0] pc = crc_of(id[55:0]);
      bit e_crc = (id[63:56] == pc);
      bit e_fam = (id[7:0] == 8'h2D);
      chk(crc_calc == pc && crc_calc_vld, {tag, " R2 prefix crc"}, {55'd0, crc_calc_vld, crc_calc}, {56'd1, pc});
      chk(crc_ok == e_crc, {tag, " R4 crc_ok"}, 64'(crc_ok), 64'(e_crc));
      chk(fam_ok == e_fam, {tag, " R5 fam_ok"}, 64'(fam_ok), 64'(e_fam));
      chk(id_ok == (e_crc && e_fam), {tag, " R6 id_ok"}, 64'(id_ok), 64'(e_crc && e_fam));
   endtask

   // parallel run; returns at the negedge where done should be high
   task automatic par_run(input logic [63:0] id, input string tag);
      bit early = 0;
      @(negedge clk); load = 1'b1; id_word = id;
      @(negedge clk); load = 1'b0; id_word = $urandom;
      chk(busy == 1'b1, {tag, " R3 busy after load"}, 64'(busy), 64'd1);
      for (int k = 1; k < 64; k++) begin
         @(negedge clk);
         if (done) early = 1;
      end
      chk(!early, {tag, " R3 no early done"}, 64'(early), 64'd0);
      @(negedge clk);
      chk(done == 1'b1 && busy == 1'b0, {tag, " R3 done at 64"}, {62'd0, done, busy}, 64'd2);
   endtask

   // serial run with optional gaps; returns at the negedge where done should be high
   task automatic ser_run(input logic [63:0] id, input bit gaps, input string tag);
      @(negedge clk); ser_clr = 1'b1;
      @(negedge clk); ser_clr = 1'b0;
      chk(!crc_calc_vld && !done && !crc_ok, {tag, " R8 cleared"}, {61'd0, crc_calc_vld, done, crc_ok}, 64'd0);
      for (int i = 0; i < 64; i++) begin
         while (gaps && ($urandom % 4 == 0)) begin
            ser_vld = 1'b0; ser_bit = $urandom;
            @(negedge clk);
         end
         ser_vld = 1'b1; ser_bit = id[i];
         @(negedge clk);
      end
      ser_vld = 1'b0;
      chk(done == 1'b1, {tag, " R8 done after 64th bit"}, 64'(done), 64'd1);
   endtask

   task automatic finish_up;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #2000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

   initial begin
      logic [63:0] a, b, g;
      seed_dummy = $urandom(32'h1D5E_0A77);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !crc_calc_vld && !crc_ok && !fam_ok && !id_ok && crc_calc == 0,
          "R1 reset outputs", {50'd0, busy, done, crc_calc_vld, crc_ok, fam_ok, id_ok, crc_calc}, 64'd0);
      rst_n = 1'b1;

      // valid identifier, parallel
      g = make_good(48'h0000_0623_4FB0, 8'h2D);
      par_run(g, "good");
      check_results(g, "good");
      @(negedge clk);
      chk(!done, "R3 done single cycle", 64'(done), 64'd0);
      // R10 hold, R9 late serial bits ignored
      ser_vld = 1'b1; ser_bit = 1'b1;
      repeat (5) @(negedge clk);
      ser_vld = 1'b0;
      check_results(g, "hold R9 R10");

      // R5 correct crc, wrong family
      par_run(make_good(48'hABCD_EF01_2345, 8'h2C), "wrongfam");
      check_results(make_good(48'hABCD_EF01_2345, 8'h2C), "wrongfam R5");
      // R4 corrupted CRC byte
      a = g ^ 64'h0100_0000_0000_0000;
      par_run(a, "badcrc");
      check_results(a, "badcrc R4");
      // all zeros
      par_run(64'd0, "zero");
      check_results(64'd0, "zero R4");
      // R10 clear on load
      @(negedge clk); load = 1'b1; id_word = g;
      @(negedge clk); load = 1'b0;
      chk(!done && !crc_calc_vld && !crc_ok && !fam_ok, "R10 clear on load",
          {60'd0, done, crc_calc_vld, crc_ok, fam_ok}, 64'd0);
      repeat (70) @(negedge clk);

      // R7 restart mid-check
      a = make_good(48'h1111_2222_3333, 8'h2D);
      b = make_good(48'h4444_5555_6666, 8'h2D) ^ 64'h10;
      @(negedge clk); load = 1'b1; id_word = a;
      @(negedge clk); load = 1'b0;
      repeat (20) @(negedge clk);
      par_run(b, "restart R7");
      check_results(b, "restart R7");

      // R8 serial, with and without gaps
      ser_run(g, 1'b0, "ser");
      check_results(g, "ser R8");
      ser_run(g ^ 64'h0000_0100_0000_0000, 1'b1, "sergap");
      check_results(g ^ 64'h0000_0100_0000_0000, "sergap R8");

      // R9 serial bits ignored while busy
      @(negedge clk); load = 1'b1; id_word = g;
      @(negedge clk); load = 1'b0;
      for (int k = 1; k < 64; k++) begin
         ser_vld = 1'b1; ser_bit = $urandom;
         @(negedge clk);
      end
      ser_vld = 1'b0;
      @(negedge clk);
      chk(done == 1'b1, "R9 done with serial noise", 64'(done), 64'd1);
      check_results(g, "busy-ignore R9");

      // random mix
      for (int it = 0; it < 40; it++) begin
         logic [63:0] r;
         case ($urandom % 3)
            0: r = make_good({$urandom, 16'($urandom)}, 8'h2D);
            1: r = make_good({$urandom, 16'($urandom)}, 8'h2D) ^ (64'd1 << ($urandom % 64));
            default: r = {$urandom, $urandom};
         endcase
         if ($urandom % 2) begin
            par_run(r, "rand par");
            check_results(r, "rand par");
         end else begin
            ser_run(r, 1'b1, "rand ser");
            check_results(r, "rand ser");
         end
      end

      finish_up();
   end
endmodule